// File: doc/BRIEF.md
# Bus Width Negotiating Cycle Splitter

This block sits between a CPU and a backplane whose cards may be eight or sixteen bits wide. It takes single byte or word requests from the CPU and runs them as bus cycles. Each cycle opens with a one-clock start strobe. During that strobe the address and status outputs are already settled.

For a word, the block raises an extended-request line together with the strobe. It then watches for the target's sixteen-bit acknowledge at a fixed clock in the negotiation window. If the acknowledge is there, the word moves in one wide cycle. If it is not, the block drops the request and moves the word as two byte cycles: the given address first, then that address plus one. It returns the assembled result only after both cycles are done.

The block also reshapes the 20-bit CPU address for the 24-bit bus. It flags accesses above the first 64 KiB so that older cards decoding only 16 bits stay silent. On request, it copies the low address byte into the middle byte for I/O cycles.

Top module: `bus_width_splitter`

## Requirements
- R1: Every bus cycle starts with `sync_o` high for exactly one clock. The cycle then has NEG_CYC window clocks and one transfer clock (`xfer_o` high). `bus_addr_o`, `phantom_o`, `io_o` and `wr_o` do not change from the strobe through the transfer clock.
- R2: A word request with `neg_en_i` high raises `xreq_o` in the strobe clock. `ack16_i` is sampled in the last window clock, which is NEG_CYC clocks after the strobe (2 by default).
- R3: If `ack16_i` is high at the sample clock, `xreq_o` stays high through the transfer clock and the word moves in that single cycle. A wide write drives the low byte on `lane_a_o` and the high byte on `lane_b_o`, with both enables high. A wide read takes the low byte from `lane_b_i` and the high byte from `lane_a_i`, with both enables low.
- R4: If `ack16_i` is low at the sample clock, `xreq_o` is low from the transfer clock on. That cycle carries the low byte at the request address. A second cycle, with `xreq_o` low throughout, carries the high byte at the address plus one; on a write the high byte goes out on `lane_a_o`.
- R5: A split word read returns `rdata_o` = {second byte, first byte}.
- R6: Byte cycles use `lane_a_o` as output (`lane_a_oe_o` = 1, `lane_b_oe_o` = 0) and read from `lane_b_i`. A byte write sends `wdata_i[7:0]`. A byte read returns {8'h00, byte}.
- R7: With `neg_en_i` low, `xreq_o` is never asserted, every word is split into two byte cycles, and `ack16_i` has no effect.
- R8: A byte request never asserts `xreq_o`, and `ack16_i` has no effect on it.
- R9: `bus_addr_o[23:20]` is always zero. `bus_addr_o[19:0]` is the address of the current cycle.
- R10: `phantom_o` is high exactly when the current cycle address is 0x10000 or above.
- R11: For an I/O cycle with `io_mirror_i` high, `bus_addr_o[15:8]` equals address bits [7:0]. For memory cycles, or with the option low, the address is passed on unchanged.
- R12: `rdy_o` is a one-clock pulse in the clock after the final transfer clock, and `rdata_o` is valid in that clock. A write returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-clock request pulse, accepted when idle |
| we_i | input | 1 | Request is a write |
| word_i | input | 1 | Request is a 16-bit word |
| io_i | input | 1 | Request targets I/O space |
| addr_i | input | 20 | CPU address |
| wdata_i | input | 16 | Write data |
| rdy_o | output | 1 | Request complete pulse |
| rdata_o | output | 16 | Read data, valid with `rdy_o` |
| neg_en_i | input | 1 | Enables width negotiation |
| io_mirror_i | input | 1 | Copies low I/O address byte to middle byte |
| sync_o | output | 1 | Start-of-cycle strobe |
| xreq_o | output | 1 | Extended (16-bit) request status |
| xfer_o | output | 1 | Data transfer clock of the cycle |
| io_o | output | 1 | I/O cycle status |
| wr_o | output | 1 | Write cycle status |
| phantom_o | output | 1 | Hides 16-bit-decoding cards above 64 KiB |
| bus_addr_o | output | 24 | Bus address |
| ack16_i | input | 1 | Target can take a 16-bit transfer |
| lane_a_o | output | 8 | Lane A drive (outbound byte lane) |
| lane_a_oe_o | output | 1 | Lane A drive enable |
| lane_a_i | input | 8 | Lane A receive (high byte of wide reads) |
| lane_b_o | output | 8 | Lane B drive (high byte of wide writes) |
| lane_b_oe_o | output | 1 | Lane B drive enable |
| lane_b_i | input | 8 | Lane B receive (inbound byte lane) |

## Verification
The assertions assume that the CPU pulses `req_i` only while the block is idle, after the previous `rdy_o`. They also assume that `neg_en_i` and `io_mirror_i` change only between requests. The address-hold and extended-request checks depend on this. The bench changes these inputs only before a request pulse, and it moves `ack16_i` only on falling edges. The acknowledge is driven steady, not at all, only in the sample clock, or only one clock too early, so the timing of the sample clock is pinned down from both sides.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_WIN,
    ST_XFER,
    ST_DONE
  } bws_state_e;
endpackage

// File: rtl/bws_addr_shape.sv
module bws_addr_shape #(
  parameter int CPU_AW   = 20,
  parameter int BUS_AW   = 24,
  parameter int BYTE_W   = 8,
  parameter int LOW_SPAN = 16
) (
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              io_i,
  input  logic              mirror_i,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic              phantom_o
);
  localparam int PAD_W = BUS_AW - CPU_AW;

  always_comb begin
    bus_addr_o = {{PAD_W{1'b0}}, cpu_addr_i};
    if (io_i && mirror_i)
      bus_addr_o[2*BYTE_W-1:BYTE_W] = cpu_addr_i[BYTE_W-1:0];
  end

  // anything outside the low window hides legacy decoders
  assign phantom_o = |cpu_addr_i[CPU_AW-1:LOW_SPAN];
endmodule

// File: rtl/bws_lane_steer.sv
module bws_lane_steer #(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic                wide_i,
  input  logic                we_i,
  input  logic                hi_sel_i,
  input  logic [BYTE_W-1:0]   lane_a_i,
  input  logic [BYTE_W-1:0]   lane_b_i,
  output logic [BYTE_W-1:0]   lane_a_o,
  output logic                lane_a_oe_o,
  output logic [BYTE_W-1:0]   lane_b_o,
  output logic                lane_b_oe_o,
  output logic [2*BYTE_W-1:0] rd_word_o,
  output logic [BYTE_W-1:0]   rd_byte_o
);
  logic [BYTE_W-1:0] lo_b, hi_b;
  assign lo_b = wdata_i[BYTE_W-1:0];
  assign hi_b = wdata_i[2*BYTE_W-1:BYTE_W];

  // byte mode: A out, B in; wide mode: both lanes turn with direction
  assign lane_a_o    = (wide_i || !hi_sel_i) ? lo_b : hi_b;
  assign lane_a_oe_o = !(wide_i && !we_i);
  assign lane_b_o    = hi_b;
  assign lane_b_oe_o = wide_i && we_i;

  assign rd_word_o = {lane_a_i, lane_b_i};
  assign rd_byte_o = lane_b_i;
endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter
  import bws_pkg::*;
#(
  parameter int CPU_AW   = 20,
  parameter int BUS_AW   = 24,
  parameter int BYTE_W   = 8,
  parameter int LOW_SPAN = 16,
  parameter int NEG_CYC  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                word_i,
  input  logic                io_i,
  input  logic [CPU_AW-1:0]   addr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  output logic                rdy_o,
  output logic [2*BYTE_W-1:0] rdata_o,
  input  logic                neg_en_i,
  input  logic                io_mirror_i,
  output logic                sync_o,
  output logic                xreq_o,
  output logic                xfer_o,
  output logic                io_o,
  output logic                wr_o,
  output logic                phantom_o,
  output logic [BUS_AW-1:0]   bus_addr_o,
  input  logic                ack16_i,
  output logic [BYTE_W-1:0]   lane_a_o,
  output logic                lane_a_oe_o,
  input  logic [BYTE_W-1:0]   lane_a_i,
  output logic [BYTE_W-1:0]   lane_b_o,
  output logic                lane_b_oe_o,
  input  logic [BYTE_W-1:0]   lane_b_i
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(NEG_CYC + 1);

  bws_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                we_q, word_q, io_q, part_q, wide_q, xreq_q;
  logic [CPU_AW-1:0]   addr_q;
  logic [WORD_W-1:0]   wdata_q, rdata_q;
  logic [BYTE_W-1:0]   lo_q;
  logic [CPU_AW-1:0]   cur_addr;
  logic [WORD_W-1:0]   rd_word;
  logic [BYTE_W-1:0]   rd_byte;
  logic                busy;

  assign cur_addr = addr_q + CPU_AW'(part_q);
  assign busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);

  bws_addr_shape #(
    .CPU_AW(CPU_AW), .BUS_AW(BUS_AW), .BYTE_W(BYTE_W), .LOW_SPAN(LOW_SPAN)
  ) i_shape (
    .cpu_addr_i(cur_addr),
    .io_i      (io_q),
    .mirror_i  (io_mirror_i),
    .bus_addr_o(bus_addr_o),
    .phantom_o (phantom_o)
  );

  bws_lane_steer #(.BYTE_W(BYTE_W)) i_steer (
    .wdata_i    (wdata_q),
    .wide_i     (wide_q),
    .we_i       (we_q),
    .hi_sel_i   (part_q),
    .lane_a_i   (lane_a_i),
    .lane_b_i   (lane_b_i),
    .lane_a_o   (lane_a_o),
    .lane_a_oe_o(lane_a_oe_o),
    .lane_b_o   (lane_b_o),
    .lane_b_oe_o(lane_b_oe_o),
    .rd_word_o  (rd_word),
    .rd_byte_o  (rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      io_q    <= 1'b0;
      part_q  <= 1'b0;
      wide_q  <= 1'b0;
      xreq_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          we_q    <= we_i;
          word_q  <= word_i;
          io_q    <= io_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          part_q  <= 1'b0;
          wide_q  <= 1'b0;
          xreq_q  <= word_i && neg_en_i;
          state_q <= ST_SYNC;
        end
        ST_SYNC: begin
          cnt_q   <= '0;
          state_q <= ST_WIN;
        end
        ST_WIN: begin
          if (cnt_q == CNT_W'(NEG_CYC - 1)) begin
            if (xreq_q) begin
              wide_q <= ack16_i;
              xreq_q <= ack16_i;
            end
            state_q <= ST_XFER;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (wide_q) begin
            rdata_q <= we_q ? '0 : rd_word;
            xreq_q  <= 1'b0;
            state_q <= ST_DONE;
          end else if (word_q && !part_q) begin
            lo_q    <= rd_byte;
            part_q  <= 1'b1;
            state_q <= ST_SYNC;
          end else begin
            rdata_q <= we_q   ? '0 :
                       word_q ? {rd_byte, lo_q} : {{BYTE_W{1'b0}}, rd_byte};
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sync_o  = (state_q == ST_SYNC);
  assign xfer_o  = (state_q == ST_XFER);
  assign rdy_o   = (state_q == ST_DONE);
  assign xreq_o  = xreq_q;
  assign io_o    = busy && io_q;
  assign wr_o    = busy && we_q;
  assign rdata_o = rdata_q;

  p_sync_one_clk_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);
  p_addr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !sync_o) |-> ($stable(bus_addr_o) && $stable(phantom_o)));
  p_xreq_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xreq_o) |-> sync_o);
  p_wide_read_lanes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xreq_o && xfer_o && !wr_o) |-> (!lane_a_oe_o && !lane_b_oe_o));
  p_xreq_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xreq_o) |-> (xfer_o || rdy_o));
  p_xreq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !neg_en_i |-> !xreq_o);
  p_rdy_after_xfer_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> ($past(xfer_o) && !xreq_o));
  p_rdy_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
endmodule

// File: tb/test_bus_width_splitter.sv
module test_bus_width_splitter;
  localparam int NEG = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, word = 1'b0, io = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        neg_en = 1'b1, mirror = 1'b0, ack = 1'b0;
  logic        rdy, sync, xreq, xfer, io_s, wr_s, phantom;
  logic [15:0] rdata;
  logic [23:0] bus_addr;
  logic [7:0]  la_o, lb_o, la_i, lb_i;
  logic        la_oe, lb_oe;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] tgt_a(logic [23:0] a);
    return a[7:0] ^ 8'hC3;
  endfunction
  function automatic logic [7:0] tgt_b(logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [23:0] exp_bus(logic [19:0] a, bit is_io, bit mir);
    logic [23:0] r;
    r = {4'h0, a};
    if (is_io && mir) r[15:8] = a[7:0];
    return r;
  endfunction

  assign la_i = tgt_a(bus_addr);
  assign lb_i = tgt_b(bus_addr);

  bus_width_splitter i_bus_width_splitter (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_i(req), .we_i(we), .word_i(word), .io_i(io), .addr_i(addr), .wdata_i(wdata),
    .rdy_o(rdy), .rdata_o(rdata), .neg_en_i(neg_en), .io_mirror_i(mirror),
    .sync_o(sync), .xreq_o(xreq), .xfer_o(xfer), .io_o(io_s), .wr_o(wr_s),
    .phantom_o(phantom), .bus_addr_o(bus_addr), .ack16_i(ack),
    .lane_a_o(la_o), .lane_a_oe_o(la_oe), .lane_a_i(la_i),
    .lane_b_o(lb_o), .lane_b_oe_o(lb_oe), .lane_b_i(lb_i)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ackmode: 0 never, 1 steady, 2 only one clock before the sample, 3 only at the sample
  task automatic run(bit w, bit wd_mode, bit is_io, logic [19:0] a0, logic [15:0] d,
                     bit neg, bit mir, int ackmode);
    bit          wide;
    int          ncyc;
    logic [23:0] ea0, ea1;
    logic [15:0] exp_rd;
    @(negedge clk);
    we = w; word = wd_mode; io = is_io; addr = a0; wdata = d;
    neg_en = neg; mirror = mir; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wide = wd_mode && neg && (ackmode == 1 || ackmode == 3);
    ncyc = (wd_mode && !wide) ? 2 : 1;
    ea0  = exp_bus(a0, is_io, mir);
    ea1  = exp_bus(a0 + 20'd1, is_io, mir);
    for (int c = 0; c < ncyc; c++) begin
      logic [19:0] ca;
      ca = a0 + 20'(c);
      for (int k = 0; k <= NEG + 1; k++) begin
        bit exp_x;
        ack = (ackmode == 1) || (ackmode == 2 && k == NEG - 1) || (ackmode == 3 && k == NEG);
        chk("R1 sync", sync, 32'(k == 0));
        chk("R1 xfer", xfer, 32'(k == NEG + 1));
        chk("R1 io status", io_s, 32'(is_io));
        chk("R1 wr status", wr_s, 32'(w));
        chk("R12 rdy low", rdy, 0);
        if (is_io) chk("R11 addr", bus_addr, 32'(exp_bus(ca, is_io, mir)));
        else       chk("R9 addr", bus_addr, 32'(exp_bus(ca, is_io, mir)));
        chk("R10 phantom", phantom, 32'(ca >= 20'h10000));
        exp_x = wd_mode && neg && c == 0 && (k <= NEG || wide);
        if (!neg)          chk("R7 xreq", xreq, 32'(exp_x));
        else if (!wd_mode) chk("R8 xreq", xreq, 32'(exp_x));
        else if (k <= NEG && c == 0) chk("R2 xreq", xreq, 32'(exp_x));
        else if (wide)     chk("R3 xreq", xreq, 32'(exp_x));
        else               chk("R4 xreq", xreq, 32'(exp_x));
        if (k == NEG + 1) begin
          if (wide) begin
            chk("R3 lane_a_oe", la_oe, 32'(w));
            chk("R3 lane_b_oe", lb_oe, 32'(w));
            if (w) begin
              chk("R3 lane_a data", la_o, 32'(d[7:0]));
              chk("R3 lane_b data", lb_o, 32'(d[15:8]));
            end
          end else begin
            chk("R6 lane_a_oe", la_oe, 1);
            chk("R6 lane_b_oe", lb_oe, 0);
            if (w && c == 0) chk("R6 lane_a data", la_o, 32'(d[7:0]));
            if (w && c == 1) chk("R4 lane_a high", la_o, 32'(d[15:8]));
          end
        end
        @(negedge clk);
      end
    end
    ack = 1'b0;
    if (w)            exp_rd = 16'h0;
    else if (wide)    exp_rd = {tgt_a(ea0), tgt_b(ea0)};
    else if (wd_mode) exp_rd = {tgt_b(ea1), tgt_b(ea0)};
    else              exp_rd = {8'h00, tgt_b(ea0)};
    chk("R12 rdy", rdy, 1);
    chk("R12 xreq done", xreq, 0);
    if (w)            chk("R12 write data", rdata, 32'(exp_rd));
    else if (wide)    chk("R3 rdata", rdata, 32'(exp_rd));
    else if (wd_mode) chk("R5 rdata", rdata, 32'(exp_rd));
    else              chk("R6 rdata", rdata, 32'(exp_rd));
    @(negedge clk);
    chk("R12 rdy pulse", rdy, 0);
    chk("R1 sync idle", sync, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sync", sync, 0);
    chk("R2 reset xreq", xreq, 0);
    chk("R12 reset rdy", rdy, 0);
    chk("R1 reset xfer", xfer, 0);
    rst_ni = 1'b1;
    run(0, 0, 0, 20'h00123, 16'h0000, 1, 0, 1);
    run(1, 0, 0, 20'h1ABCD, 16'h00E7, 1, 0, 0);
    run(0, 1, 0, 20'h04000, 16'h0000, 1, 0, 1);
    run(1, 1, 0, 20'h20010, 16'hBEEF, 1, 0, 3);
    run(0, 1, 0, 20'h0FFFE, 16'h0000, 1, 0, 0);
    run(0, 1, 0, 20'h0FFFF, 16'h0000, 1, 0, 0);
    run(1, 1, 0, 20'h00200, 16'h1234, 1, 0, 2);
    run(0, 1, 0, 20'h30000, 16'h0000, 0, 0, 1);
    run(1, 1, 0, 20'h00456, 16'hA55A, 0, 0, 3);
    run(0, 0, 1, 20'h00042, 16'h0000, 1, 1, 0);
    run(1, 0, 1, 20'h00042, 16'h0099, 1, 0, 0);
    run(0, 0, 0, 20'h00077, 16'h0000, 1, 1, 1);
    run(0, 1, 0, 20'hFFFFE, 16'h0000, 1, 0, 1);
    run(0, 1, 1, 20'h000F0, 16'h0000, 1, 1, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule